// File: doc/BRIEF.md
# Two-Stage Cascaded 16:1 / 8:1 Serializer Tree

This block turns a parallel word into a single serial bit stream through a tree of small serializer cells. Each cell has its own step counter, holds a copy of its parallel inputs, and sends them out one at a time in a fixed order. Each cell also emits a pulse once per full pass through its inputs. That pulse is the divided clock.

In the default 16-bit configuration, four first-stage 4:1 cells each take a quarter of the word. Their outputs feed the four inputs of one second-stage 4:1 cell, which drives the output pin. With WORD_W set to 8, the first stage is built from four 2:1 cells instead.

Everything runs on one fast clock, and the divided clocks become clock enables:
- The second-stage cell steps on every cycle.
- Its divided pulse steps the first-stage cells.
- The divided pulse of the first stage is exported as `word_strobe`. It marks the cycle in which the upstream source must present the next word on `data_i`.

Top module: `ser_tree`

## Requirements
- R1: `word_strobe` is a single-cycle pulse, and successive pulses are exactly WORD_W cycles apart.
- R2: `data_i` is sampled only at the rising edge that ends a cycle in which `word_strobe` is high. Its value in every other cycle has no effect on `serial_o`.
- R3: Bit position p (0 ≤ p < WORD_W) of a captured word is on `serial_o` from the (5+p)-th rising edge after the capture edge until the next edge. Consecutive words follow each other with no gap.
- R4: With MSB_FIRST=1 and WORD_W=16, position p carries `data_i[15 - (4*(p%4) + p/4)]`. The stream therefore starts with bits 15, 11, 7, 3, 14, and so on. In general, with F = WORD_W/4, index i = F*(p%4) + p/4 is the input at slot p/4 of first-stage cell p%4.
- R5: With MSB_FIRST=0, position p carries `data_i[i]`, where i is the index defined in R4.
- R6: With WORD_W=8, the first stage uses 2:1 cells (F=2). The word period is 8 cycles, and the order is the R4/R5 mapping with F=2.
- R7: While `rst_n` is low, `serial_o` and `word_strobe` are 0. `serial_o` stays 0 until the first bit of the first captured word appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (bit-rate) clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| data_i | input | WORD_W | Parallel word, sampled at the edge ending a `word_strobe` cycle |
| word_strobe | output | 1 | Word-rate pulse for the upstream source |
| serial_o | output | 1 | Registered serial data output |

## Verification
Three configurations are driven: 16:1 with MSB first, 16:1 with LSB first, and 8:1 with MSB first. Each one receives a run of words rebuilt bit by bit from the serial output.

The directed words each target a specific fault:
- All ones and all zeros expose stuck outputs.
- A single set bit at the top or bottom index pins down the first and last slots.
- An alternating pattern separates the interleave between cells from a plain shift.

Random words then cover the rest. Between strobes, `data_i` is loaded with unrelated random values. A design that samples in the wrong cycle therefore produces mismatched bits instead of passing by luck.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // Fan-in of the second (output) stage cell; fixed by the tree shape.
  localparam int unsigned OUT_FANIN = 4;

  // Parallel index carried by serial position p when each first-stage
  // cell has fan-in f (before any MSB-first reversal).
  function automatic int unsigned slot_to_index(input int unsigned p,
                                                input int unsigned f);
    return f * (p % OUT_FANIN) + (p / OUT_FANIN);
  endfunction
endpackage

// File: rtl/ser_rst_sync.sv
module ser_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ser_cell.sv
module ser_cell #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [N-1:0] d,
  output logic         q,
  output logic         div_o
);
  localparam int unsigned CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [N-1:0]  hold_q, hold_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign div_o   = ce && at_last;

  always_comb begin
    cnt_d  = cnt_q;
    hold_d = hold_q;
    if (ce) begin
      cnt_d = at_last ? '0 : cnt_q + CW'(1);
    end
    if (div_o) begin
      hold_d = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  assign q = hold_q[cnt_q];
endmodule

// File: rtl/ser_tree.sv
module ser_tree #(
  parameter int unsigned WORD_W    = 16,
  parameter bit          MSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] data_i,
  output logic              word_strobe,
  output logic              serial_o
);
  import ser_pkg::*;

  localparam int unsigned FANIN1 = WORD_W / OUT_FANIN;

  logic                  rst_sync_n;
  logic [WORD_W-1:0]     ordered;
  logic [OUT_FANIN-1:0]  s1_q;
  logic [OUT_FANIN-1:0]  s1_div;
  logic                  s1_ce;
  logic                  s2_q;
  logic                  ser_d;

  ser_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  // Bit order chosen at elaboration.
  for (genvar i = 0; i < WORD_W; i++) begin : g_order
    if (MSB_FIRST) begin : g_msb
      assign ordered[i] = data_i[WORD_W-1-i];
    end else begin : g_lsb
      assign ordered[i] = data_i[i];
    end
  end

  // First stage: 4:1 cells for 16-bit words, 2:1 cells for 8-bit words.
  for (genvar k = 0; k < OUT_FANIN; k++) begin : g_stage1
    ser_cell #(.N(FANIN1)) u_cell (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .ce   (s1_ce),
      .d    (ordered[FANIN1*k +: FANIN1]),
      .q    (s1_q[k]),
      .div_o(s1_div[k])
    );
  end

  // Second stage steps every fast cycle; its divided pulse clocks stage 1.
  ser_cell #(.N(OUT_FANIN)) u_stage2 (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .ce   (1'b1),
    .d    (s1_q),
    .q    (s2_q),
    .div_o(s1_ce)
  );

  // All first-stage cells run in lockstep.
  assign word_strobe = &s1_div;

  always_comb begin
    ser_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      serial_o <= 1'b0;
    end else begin
      serial_o <= ser_d;
    end
  end
endmodule

// File: rtl/ser_tree_chk.sv
module ser_tree_chk #(
  parameter int unsigned WORD_W    = 16,
  parameter bit          MSB_FIRST = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] data_i,
  input logic              word_strobe,
  input logic              serial_o
);
  localparam int unsigned FANIN1 = WORD_W / 4;
  localparam int unsigned IDX0 = MSB_FIRST ? WORD_W - 1 : 0;
  localparam int unsigned IDX1 = MSB_FIRST ? WORD_W - 1 - FANIN1 : FANIN1;
  localparam int unsigned GW = $clog2(WORD_W) + 1;

  logic [GW-1:0] gap_q;
  logic          seen_q;
  logic [2:0]    age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      age_q  <= '0;
    end else begin
      if (word_strobe) begin
        gap_q <= '0;
      end else if (gap_q < GW'(WORD_W)) begin
        gap_q <= gap_q + GW'(1);
      end
      if (word_strobe && !seen_q) begin
        seen_q <= 1'b1;
        age_q  <= '0;
      end else if (seen_q && age_q < 3'd7) begin
        age_q <= age_q + 3'd1;
      end
    end
  end

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    word_strobe |=> !word_strobe);

  a_r1_period: assert property (@(posedge clk) disable iff (!rst_n)
    (word_strobe && seen_q) |-> (gap_q == GW'(WORD_W - 1)));

  a_r3_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $past(word_strobe, 6) |-> (serial_o == $past(data_i[IDX0], 6)));

  a_r4_second_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $past(word_strobe, 7) |-> (serial_o == $past(data_i[IDX1], 7)));

  a_r7_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    !(seen_q && age_q >= 3'd5) |-> !serial_o);
endmodule

bind ser_tree ser_tree_chk #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .data_i     (data_i),
  .word_strobe(word_strobe),
  .serial_o   (serial_o)
);

// File: tb/tb_ser_tree.sv
module tb_ser_lane #(
  parameter int unsigned W     = 16,
  parameter bit          MSBF  = 1'b1,
  parameter string       TAG   = "R4",
  parameter int unsigned WORDS = 60,
  parameter int unsigned SEED  = 1
) (
  input  logic clk,
  input  logic rst_n,
  output int   checks,
  output int   errs,
  output logic done
);
  logic [W-1:0] data;
  logic         ws;
  logic         ser;

  ser_tree #(.WORD_W(W), .MSB_FIRST(MSBF)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_i     (data),
    .word_strobe(ws),
    .serial_o   (ser)
  );

  logic [W-1:0] q_word[$];
  int           q_start[$];
  int           cyc;
  int           last_ws;
  int           sent;
  int           got;
  int unsigned  rs;

  function automatic logic exp_bit(input logic [W-1:0] w, input int p);
    int idx;
    idx = (W / 4) * (p % 4) + (p / 4);
    return MSBF ? w[W-1-idx] : w[idx];
  endfunction

  function automatic logic [W-1:0] pick_word(input int n, input int unsigned r);
    case (n)
      0: return '1;
      1: return '0;
      2: return W'(1) << (W - 1);
      3: return W'(1);
      4: return {(W/2){2'b10}};
      default: return W'(r);
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s lane %s cyc %0d: actual=%b expected=%b", req, TAG, cyc, act, expv);
    end
  endtask

  initial begin
    checks = 0; errs = 0; done = 1'b0;
    cyc = 0; last_ws = -1; sent = 0; got = 0;
    rs = $urandom(SEED);
    data = '0;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      check("R7", ser, 1'b0);
      check("R7", ws, 1'b0);
    end else begin
      // Serial check: R2 (garbage between strobes), R3 timing, lane order tag.
      if (q_word.size() > 0 && cyc >= q_start[0]) begin
        checks++;
        if (ser !== exp_bit(q_word[0], cyc - q_start[0])) begin
          errs++;
          $display("FAIL R2 R3 %s cyc %0d pos %0d: actual=%b expected=%b",
                   TAG, cyc, cyc - q_start[0], ser, exp_bit(q_word[0], cyc - q_start[0]));
        end
        if (cyc - q_start[0] == W - 1) begin
          void'(q_word.pop_front());
          void'(q_start.pop_front());
          got++;
          if (got >= WORDS) done = 1'b1;
        end
      end else if (got == 0 && q_word.size() <= 1) begin
        check("R7", ser, 1'b0);
      end
      if (ws) begin
        if (last_ws >= 0) check("R1", 1'b1, (cyc - last_ws) == W);
        last_ws = cyc;
        if (sent < WORDS) begin
          data = pick_word(sent, $urandom);
          q_word.push_back(data);
          q_start.push_back(cyc + 6);
          sent++;
        end
      end else begin
        // R2: unrelated values outside the strobe cycle must not matter.
        data = W'($urandom);
        if (last_ws >= 0 && cyc - last_ws == 1) check("R1", ws, 1'b0);
      end
      cyc++;
    end
  end
endmodule

module tb_ser_tree;
  logic clk;
  logic rst_n;
  int   c16, e16, c16l, e16l, c8, e8;
  logic d16, d16l, d8;
  int   wd_errs;
  int   ncyc;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  tb_ser_lane #(.W(16), .MSBF(1'b1), .TAG("R4"), .SEED(11)) u_l16 (
    .clk(clk), .rst_n(rst_n), .checks(c16), .errs(e16), .done(d16));
  tb_ser_lane #(.W(16), .MSBF(1'b0), .TAG("R5"), .SEED(22)) u_l16l (
    .clk(clk), .rst_n(rst_n), .checks(c16l), .errs(e16l), .done(d16l));
  tb_ser_lane #(.W(8), .MSBF(1'b1), .TAG("R6"), .SEED(33)) u_l8 (
    .clk(clk), .rst_n(rst_n), .checks(c8), .errs(e8), .done(d8));

  initial begin
    wd_errs = 0;
    ncyc = 0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    while (!(d16 && d16l && d8) && ncyc < 20000) begin
      @(negedge clk);
      ncyc++;
    end
    if (!(d16 && d16l && d8)) begin
      wd_errs = 1;
      $display("FAIL watchdog: actual=timeout expected=all lanes done");
    end
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks",
             e16 + e16l + e8 + wd_errs, c16 + c16l + c8 + wd_errs);
    $finish;
  end
endmodule